// File: doc/BRIEF.md
# Layer-2 tunnel encapsulation header builder

This block wraps an inner Ethernet frame for transport across a routed network. The inner frame arrives as a byte stream with first/last markers. Alongside it come the result of the forwarding lookup and the frame's byte length. The lookup result is a hit flag, the remote endpoint's unicast address, the segment's multicast group and the 24-bit segment identifier. The block emits a new byte stream. The stream begins with a 50-byte outer header: Ethernet, IPv4, UDP and an 8-byte tunnel header. The inner frame follows it byte for byte, with no CRC of its own.

The UDP source port does not name an application. It carries a 15-bit hash of the inner destination MAC, source MAC and EtherType, with its top bit set. Switches that hash only on outer headers therefore still spread distinct inner flows across parallel links. The first 14 inner bytes are needed to compute that hash. The block therefore accepts and holds them before it sends the header, then replays them after the header and passes the remainder of the frame straight through. Both the IPv4 and UDP length fields and the IPv4 header checksum are derived from the length presented with the first inner byte.

Top module: `tnl_encap`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each frame is output as 50 header bytes followed by all inner bytes unchanged. `out_first` marks header byte 0 and `out_last` marks the final inner byte.
- R3: Header bytes 0-5 hold the outer destination MAC, most significant byte first. On a hit (`in_hit`=1) it is `GW_MAC`; on a flood it is 01:00:5E followed by a 0 bit and bits 22..0 of the multicast group. Bytes 6-11 hold `LOCAL_MAC`, and bytes 12-13 hold 0x0800.
- R4: Header bytes 14-33 form an IPv4 header in big-endian order. It holds 0x45, 0x00, a total length equal to the inner length plus 36, identification 0 and flags/offset 0x4000. It then holds `TTL`, protocol 17, the checksum (bytes 24-25), `LOCAL_IP`, and the destination IP. The destination IP is the unicast address on a hit and the multicast group on a flood.
- R5: The ones'-complement sum of the ten 16-bit words in bytes 14-33, including the checksum, equals 0xFFFF.
- R6: Bytes 34-35 hold the UDP source port, big-endian. Its value is 0x8000 | (c[14:0] ^ c[15]), where c is a CRC-16 over inner bytes 0-13. The CRC uses polynomial 0x1021, initial value 0xFFFF, is MSB first and has no final XOR.
- R7: Bytes 36-37 hold `DST_PORT`, bytes 38-39 hold the inner length plus 16, and bytes 40-41 are zero.
- R8: Byte 42 is 0x08 and bytes 43-45 are zero. Bytes 46-48 hold the segment identifier, most significant byte first, and byte 49 is zero.
- R9: `in_ready` is 0 while header bytes and the replayed first 14 inner bytes are being sent. Header byte 0 is valid in the cycle after the 14th inner byte is accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output byte is held unchanged into the next cycle.
- R11: The lookup inputs and the length are sampled with the first inner byte. Changing them later in the same frame has no effect on that frame's header.
- R12: For a 14-byte inner frame, `out_last` marks the last replayed byte and the block then accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inner byte valid |
| in_ready | output | 1 | Inner byte accepted when high with in_valid |
| in_data | input | 8 | Inner frame byte |
| in_first | input | 1 | First byte of inner frame |
| in_last | input | 1 | Last byte of inner frame |
| in_len | input | 16 | Inner frame length in bytes (sampled with first byte) |
| in_hit | input | 1 | 1: unicast to known endpoint, 0: flood to group |
| in_ucast_ip | input | 32 | Remote endpoint IPv4 address |
| in_mcast_ip | input | 32 | Segment multicast group address |
| in_vni | input | 24 | Segment identifier |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Encapsulated frame byte |
| out_first | output | 1 | First byte of encapsulated frame |
| out_last | output | 1 | Last byte of encapsulated frame |

## Verification
Every handshake beat counts as a transfer at the following rising edge. The bench therefore drives inputs just after the falling edge, lets them settle, and then compares any output byte that both sides mark valid and ready against a reference queue built behaviourally from the requirements. Header byte 0 is due exactly one cycle after the 14th inner byte is accepted, because only the state register lies between them. That cycle is checked on its own, as is the byte held one cycle later under back-pressure. During the 64 bytes of header and replay, `in_ready` is checked low on every beat. Frames of 14, 15, 40, 64, 100 and 300 bytes exercise unicast and flood, and the lookup inputs are changed in the middle of one frame.

// File: rtl/tnl_pkg.sv
// Shared constants, field widths, state type and CRC step for the tunnel
// encapsulator. Assumes big-endian wire order for all multi-byte fields.
package tnl_pkg;
    localparam int LEN_W      = 16;
    localparam int IP_W       = 32;
    localparam int SEG_W      = 24;
    localparam int HDR_BYTES  = 50;   // 14 + 20 + 8 + 8
    localparam int KEY_BYTES  = 14;   // inner dst MAC, src MAC, EtherType
    localparam logic [15:0] IP_EXTRA  = 16'd36;
    localparam logic [15:0] UDP_EXTRA = 16'd16;

    typedef enum logic [1:0] {ST_CAPT, ST_HDR, ST_REPLAY, ST_PASS} enc_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             hit;
        logic [IP_W-1:0]  ucast;
        logic [IP_W-1:0]  mcast;
        logic [SEG_W-1:0] seg;
    } lookup_t;

    // One byte of CRC-16, polynomial 0x1021, MSB first.
    function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int b = 0; b < 8; b++)
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction
endpackage

// File: rtl/tnl_key_capture.sv
// Holds the first KEY_BYTES bytes of an inner frame and accumulates their
// CRC-16 for the flow hash. Assumes the writer never writes past KEY_BYTES
// before a clear, and that clr and wr_en are not both asserted.
module tnl_key_capture #(
    parameter int KEY_BYTES = 14
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr_en,
    input  logic [7:0]                     wr_data,
    input  logic                           wr_last,
    input  logic [$clog2(KEY_BYTES)-1:0]   rd_idx,
    output logic [$clog2(KEY_BYTES+1)-1:0] cnt,
    output logic [7:0]                     rd_data,
    output logic [15:0]                    crc,
    output logic                           saw_last
);
    import tnl_pkg::*;
    localparam int IW = $clog2(KEY_BYTES);

    logic [7:0] mem [KEY_BYTES];

    // Byte store: written in arrival order, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) mem[cnt[IW-1:0]] <= wr_data;
    end

    // Count, running CRC and end-of-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            crc      <= 16'hFFFF;
            saw_last <= 1'b0;
        end else if (wr_en) begin
            cnt      <= cnt + 1'b1;
            crc      <= crc16_step(crc, wr_data);
            saw_last <= wr_last;
        end
    end

    assign rd_data = mem[rd_idx];

    // R6 (the hash key never grows beyond the captured header bytes)
    key_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ($clog2(KEY_BYTES+1))'(KEY_BYTES));
endmodule

// File: rtl/tnl_hdr_gen.sv
// Builds the 50-byte outer header from the sampled lookup result and the
// flow hash, and returns the byte selected by idx. Assumes the inputs are
// held stable while the header is being sent.
module tnl_hdr_gen #(
    parameter logic [47:0] LOCAL_MAC = 48'h02_00_00_00_00_01,
    parameter logic [47:0] GW_MAC    = 48'h02_00_00_00_00_FE,
    parameter logic [31:0] LOCAL_IP  = 32'h0A_00_00_01,
    parameter logic [15:0] DST_PORT  = 16'd4789,
    parameter logic [7:0]  TTL       = 8'd64
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  tnl_pkg::lookup_t                     lk,
    input  logic [15:0]                          src_port,
    input  logic [$clog2(tnl_pkg::HDR_BYTES)-1:0] idx,
    output logic [7:0]                           hdr_byte
);
    import tnl_pkg::*;

    logic [7:0]  hdr [HDR_BYTES];
    logic [47:0] dmac;
    logic [31:0] dip;
    logic [15:0] tot_len, udp_len, csum;
    logic [19:0] acc;
    logic [16:0] fold1;
    logic [16:0] fold2;

    // Destination selection and IPv4 checksum from the fields that vary.
    always_comb begin
        dmac    = lk.hit ? GW_MAC : {24'h01005E, 1'b0, lk.mcast[22:0]};
        dip     = lk.hit ? lk.ucast : lk.mcast;
        tot_len = lk.len + IP_EXTRA;
        udp_len = lk.len + UDP_EXTRA;
        acc     = 20'h04500 + 20'(tot_len) + 20'h04000 + 20'({TTL, 8'd17})
                + 20'(LOCAL_IP[31:16]) + 20'(LOCAL_IP[15:0])
                + 20'(dip[31:16]) + 20'(dip[15:0]);
        fold1   = 17'(acc[15:0]) + 17'(acc[19:16]);
        fold2   = 17'(fold1[15:0]) + 17'(fold1[16]);
        csum    = ~fold2[15:0];
    end

    // Header byte image in wire order.
    always_comb begin
        for (int k = 0; k < 6; k++) begin
            hdr[k]     = dmac[8*(5-k) +: 8];
            hdr[6 + k] = LOCAL_MAC[8*(5-k) +: 8];
        end
        hdr[12] = 8'h08;  hdr[13] = 8'h00;
        hdr[14] = 8'h45;  hdr[15] = 8'h00;
        hdr[16] = tot_len[15:8]; hdr[17] = tot_len[7:0];
        hdr[18] = 8'h00;  hdr[19] = 8'h00;
        hdr[20] = 8'h40;  hdr[21] = 8'h00;
        hdr[22] = TTL;    hdr[23] = 8'd17;
        hdr[24] = csum[15:8]; hdr[25] = csum[7:0];
        for (int k = 0; k < 4; k++) begin
            hdr[26 + k] = LOCAL_IP[8*(3-k) +: 8];
            hdr[30 + k] = dip[8*(3-k) +: 8];
        end
        hdr[34] = src_port[15:8]; hdr[35] = src_port[7:0];
        hdr[36] = DST_PORT[15:8]; hdr[37] = DST_PORT[7:0];
        hdr[38] = udp_len[15:8];  hdr[39] = udp_len[7:0];
        hdr[40] = 8'h00;  hdr[41] = 8'h00;
        hdr[42] = 8'h08;  hdr[43] = 8'h00; hdr[44] = 8'h00; hdr[45] = 8'h00;
        hdr[46] = lk.seg[23:16]; hdr[47] = lk.seg[15:8]; hdr[48] = lk.seg[7:0];
        hdr[49] = 8'h00;
    end

    assign hdr_byte = hdr[idx];

    // Independent re-sum of the emitted IPv4 header words.
    logic [19:0] vsum;
    logic [16:0] vf1, vf2;
    always_comb begin
        vsum = '0;
        for (int w = 0; w < 10; w++)
            vsum = vsum + 20'({hdr[14 + 2*w], hdr[15 + 2*w]});
        vf1 = 17'(vsum[15:0]) + 17'(vsum[19:16]);
        vf2 = 17'(vf1[15:0]) + 17'(vf1[16]);
    end

    // R5
    hdr_csum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vf2[15:0] == 16'hFFFF);
endmodule

// File: rtl/tnl_encap.sv
// Top of the tunnel encapsulator. Sequence per frame: capture 14 inner
// bytes (hash key), send 50 header bytes, replay the 14 bytes, then pass
// the rest through. Assumes inner frames are at least 14 bytes, the first
// beat carries in_first, and in_len matches the frame length.
module tnl_encap #(
    parameter logic [47:0] LOCAL_MAC = 48'h02_00_00_00_00_01,
    parameter logic [47:0] GW_MAC    = 48'h02_00_00_00_00_FE,
    parameter logic [31:0] LOCAL_IP  = 32'h0A_00_00_01,
    parameter logic [15:0] DST_PORT  = 16'd4789,
    parameter logic [7:0]  TTL       = 8'd64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [7:0]                 in_data,
    input  logic                       in_first,
    input  logic                       in_last,
    input  logic [tnl_pkg::LEN_W-1:0]  in_len,
    input  logic                       in_hit,
    input  logic [tnl_pkg::IP_W-1:0]   in_ucast_ip,
    input  logic [tnl_pkg::IP_W-1:0]   in_mcast_ip,
    input  logic [tnl_pkg::SEG_W-1:0]  in_vni,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [7:0]                 out_data,
    output logic                       out_first,
    output logic                       out_last
);
    import tnl_pkg::*;
    localparam int HW = $clog2(HDR_BYTES);
    localparam int IW = $clog2(KEY_BYTES);
    localparam int CW = $clog2(KEY_BYTES + 1);

    enc_state_e     state;
    logic [HW-1:0]  hidx;
    logic [IW-1:0]  ridx;
    lookup_t        lk;
    logic [CW-1:0]  cnt;
    logic [7:0]     key_byte, hdr_byte;
    logic [15:0]    key_crc, src_port;
    logic           saw_last, cap_wr, last_key, clr;

    assign cap_wr   = (state == ST_CAPT) && in_valid;
    assign last_key = cap_wr && (cnt == CW'(KEY_BYTES - 1));
    assign clr      = ((state == ST_REPLAY) && out_ready && (ridx == IW'(KEY_BYTES - 1)) && saw_last)
                   || ((state == ST_PASS) && in_valid && out_ready && in_last);
    assign src_port = {1'b1, key_crc[14:0] ^ {14'd0, key_crc[15]}};

    tnl_key_capture #(.KEY_BYTES(KEY_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(cap_wr), .wr_data(in_data),
        .wr_last(in_last), .rd_idx(ridx), .cnt(cnt), .rd_data(key_byte),
        .crc(key_crc), .saw_last(saw_last)
    );

    tnl_hdr_gen #(
        .LOCAL_MAC(LOCAL_MAC), .GW_MAC(GW_MAC), .LOCAL_IP(LOCAL_IP),
        .DST_PORT(DST_PORT), .TTL(TTL)
    ) u_hdr (
        .clk(clk), .rst_n(rst_n), .lk(lk), .src_port(src_port),
        .idx(hidx), .hdr_byte(hdr_byte)
    );

    // Sample the lookup result with the first inner byte of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lk <= '0;
        else if (cap_wr && in_first)
            lk <= '{len: in_len, hit: in_hit, ucast: in_ucast_ip,
                    mcast: in_mcast_ip, seg: in_vni};
    end

    // Frame sequencer: capture, header, replay, pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CAPT;
            hidx  <= '0;
            ridx  <= '0;
        end else begin
            unique case (state)
                ST_CAPT: if (last_key) begin
                    state <= ST_HDR;
                    hidx  <= '0;
                end
                ST_HDR: if (out_ready) begin
                    if (hidx == HW'(HDR_BYTES - 1)) begin
                        state <= ST_REPLAY;
                        ridx  <= '0;
                    end else begin
                        hidx <= hidx + 1'b1;
                    end
                end
                ST_REPLAY: if (out_ready) begin
                    if (ridx == IW'(KEY_BYTES - 1))
                        state <= saw_last ? ST_CAPT : ST_PASS;
                    else
                        ridx <= ridx + 1'b1;
                end
                ST_PASS: if (in_valid && out_ready && in_last)
                    state <= ST_CAPT;
                default: state <= ST_CAPT;
            endcase
        end
    end

    // Output mux and inner-stream back-pressure per state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_first = 1'b0;
        out_last  = 1'b0;
        unique case (state)
            ST_CAPT: in_ready = 1'b1;
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_byte;
                out_first = (hidx == '0);
            end
            ST_REPLAY: begin
                out_valid = 1'b1;
                out_data  = key_byte;
                out_last  = saw_last && (ridx == IW'(KEY_BYTES - 1));
            end
            ST_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last;
            end
            default: ;
        endcase
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != ST_PASS) |=> (out_valid && $stable(out_data)));
    // R9
    first_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_key |=> (out_valid && out_first));
    // R2
    last_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
    // R9
    no_inner_during_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_first) |-> !in_ready);
endmodule

// File: tb/tnl_encap_bench.sv
module tnl_encap_bench;
    localparam logic [47:0] L_MAC  = 48'h02_11_22_33_44_55;
    localparam logic [47:0] G_MAC  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [31:0] L_IP   = 32'hC0A8_0A01;
    localparam logic [15:0] D_PORT = 16'd4789;
    localparam logic [7:0]  T_TTL  = 8'd32;
    localparam int LIMIT = 20000;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_first = 0, in_last = 0, in_hit = 0, out_ready = 0;
    logic [7:0] in_data = 0;
    logic [15:0] in_len = 0;
    logic [31:0] in_ucast_ip = 0, in_mcast_ip = 0;
    logic [23:0] in_vni = 0;
    logic in_ready, out_valid, out_first, out_last;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    tnl_encap #(.LOCAL_MAC(L_MAC), .GW_MAC(G_MAC), .LOCAL_IP(L_IP),
                .DST_PORT(D_PORT), .TTL(T_TTL)) u_tnl_encap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_len(in_len),
        .in_hit(in_hit), .in_ucast_ip(in_ucast_ip), .in_mcast_ip(in_mcast_ip),
        .in_vni(in_vni), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_first(out_first), .out_last(out_last));

    int checks = 0, fails = 0;

    // stimulus beats
    logic [7:0] bq_d[$];
    bit bq_f[$], bq_l[$], bq_chg[$];
    int bq_fr[$], bq_i[$];
    // expected output
    logic [7:0] eq_d[$];
    bit eq_f[$], eq_l[$];
    int eq_fr[$], eq_pos[$];
    // frame table
    int f_len[8]; bit f_hit[8]; bit f_chg[8];
    logic [31:0] f_uc[8], f_mc[8]; logic [23:0] f_vni[8];
    int nfr = 0;

    task automatic add_frame(input int len, input bit hit, input logic [31:0] uc,
                             input logic [31:0] mc, input logic [23:0] vni,
                             input int seed, input bit chg);
        logic [7:0] inner[$];
        logic [7:0] h[50];
        logic [15:0] c, port, tl, ul, cs;
        logic [47:0] dm;
        logic [31:0] dip;
        int s;
        for (int i = 0; i < len; i++) inner.push_back(8'((seed * 29 + i * 13 + i * i) & 255));
        // flow hash: CRC-16 0x1021, init FFFF, MSB first over bytes 0..13
        c = 16'hFFFF;
        for (int i = 0; i < 14; i++) begin
            c = c ^ (16'(inner[i]) << 8);
            for (int b = 0; b < 8; b++)
                if (c[15]) c = (c << 1) ^ 16'h1021; else c = c << 1;
        end
        port = 16'h8000 | {1'b0, c[14:0] ^ {14'd0, c[15]}};
        dm  = hit ? G_MAC : {8'h01, 8'h00, 8'h5E, 1'b0, mc[22:0]};
        dip = hit ? uc : mc;
        tl = 16'(len + 36); ul = 16'(len + 16);
        for (int k = 0; k < 6; k++) begin h[k] = dm[47 - 8*k -: 8]; h[6+k] = L_MAC[47 - 8*k -: 8]; end
        h[12] = 8'h08; h[13] = 8'h00; h[14] = 8'h45; h[15] = 8'h00;
        h[16] = tl[15:8]; h[17] = tl[7:0]; h[18] = 0; h[19] = 0; h[20] = 8'h40; h[21] = 0;
        h[22] = T_TTL; h[23] = 8'd17; h[24] = 0; h[25] = 0;
        for (int k = 0; k < 4; k++) begin h[26+k] = L_IP[31 - 8*k -: 8]; h[30+k] = dip[31 - 8*k -: 8]; end
        s = 0;
        for (int w = 0; w < 10; w++) s += {h[14 + 2*w], h[15 + 2*w]};
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        cs = ~16'(s); h[24] = cs[15:8]; h[25] = cs[7:0];
        h[34] = port[15:8]; h[35] = port[7:0]; h[36] = D_PORT[15:8]; h[37] = D_PORT[7:0];
        h[38] = ul[15:8]; h[39] = ul[7:0]; h[40] = 0; h[41] = 0;
        h[42] = 8'h08; h[43] = 0; h[44] = 0; h[45] = 0;
        h[46] = vni[23:16]; h[47] = vni[15:8]; h[48] = vni[7:0]; h[49] = 0;
        for (int p = 0; p < 50; p++) begin
            eq_d.push_back(h[p]); eq_f.push_back(p == 0); eq_l.push_back(0);
            eq_fr.push_back(nfr); eq_pos.push_back(p);
        end
        for (int i = 0; i < len; i++) begin
            eq_d.push_back(inner[i]); eq_f.push_back(0); eq_l.push_back(i == len - 1);
            eq_fr.push_back(nfr); eq_pos.push_back(50 + i);
            bq_d.push_back(inner[i]); bq_f.push_back(i == 0); bq_l.push_back(i == len - 1);
            bq_chg.push_back(chg && i == 5); bq_fr.push_back(nfr); bq_i.push_back(i);
        end
        f_len[nfr] = len; f_hit[nfr] = hit; f_uc[nfr] = uc; f_mc[nfr] = mc;
        f_vni[nfr] = vni; f_chg[nfr] = chg; nfr++;
    endtask

    function automatic string tag_of(int pos, int fr);
        if (f_chg[fr] && pos < 50) return "R11";
        if (pos < 14) return "R3";
        if (pos == 24 || pos == 25) return "R5";
        if (pos < 34) return "R4";
        if (pos < 36) return "R6";
        if (pos < 42) return "R7";
        if (pos < 50) return "R8";
        return "R2";
    endfunction

    initial begin
        int cycles = 0, ptr = 0;
        bit acc = 0, exp_hdr = 0, held_v = 0;
        logic [7:0] held = 0;
        logic [15:0] lfsr = 16'hACE1;

        add_frame(14,  1, 32'h0A00_0105, 32'hEF01_0203, 24'h123456, 1, 0); // R12
        add_frame(15,  0, 32'h0A00_0106, 32'hEFAB_CDEF, 24'h000001, 2, 0);
        add_frame(64,  1, 32'h0A00_0107, 32'hEF00_0001, 24'hABCDEF, 3, 1); // R11
        add_frame(100, 0, 32'h0A00_0108, 32'hEFFF_FFFF, 24'hFFFFFF, 4, 0);
        add_frame(40,  1, 32'hFFFF_FFFF, 32'hE000_0000, 24'h000000, 5, 0);
        add_frame(300, 0, 32'h0102_0304, 32'hE07F_0080, 24'h5A5A5A, 6, 0);

        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: out_valid=%b in_ready=%b expected 0/1", out_valid, in_ready);
        end

        while ((eq_d.size() > 0 || ptr < bq_d.size()) && cycles < LIMIT) begin
            @(negedge clk);
            cycles++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (acc) begin in_valid = 0; ptr++; acc = 0; end
            if (!in_valid && ptr < bq_d.size() && (lfsr[2] | lfsr[3])) begin
                int fr;
                fr = bq_fr[ptr];
                in_valid = 1; in_data = bq_d[ptr]; in_first = bq_f[ptr]; in_last = bq_l[ptr];
                if (bq_f[ptr]) begin
                    in_len = 16'(f_len[fr]); in_hit = f_hit[fr]; in_ucast_ip = f_uc[fr];
                    in_mcast_ip = f_mc[fr]; in_vni = f_vni[fr];
                end
                if (bq_chg[ptr]) begin // R11: disturb lookup inputs mid-frame
                    in_len = 16'h0BAD; in_hit = ~in_hit; in_ucast_ip = 32'h0;
                    in_mcast_ip = 32'h0; in_vni = 24'h0;
                end
            end
            out_ready = (eq_fr.size() > 0 && eq_fr[0] == 4) ? 1'b1 : (lfsr[0] | lfsr[1]);
            #1;
            // R9 latency: header byte 0 one cycle after the 14th inner byte
            if (exp_hdr) begin
                checks++;
                if (!(out_valid && out_first)) begin
                    fails++;
                    $display("FAIL R9 latency: out_valid=%b out_first=%b expected 1/1", out_valid, out_first);
                end
                exp_hdr = 0;
            end
            // R10 hold under back-pressure
            if (held_v) begin
                checks++;
                if (!(out_valid && out_data == held)) begin
                    fails++;
                    $display("FAIL R10 hold: out_valid=%b data=%h expected 1/%h", out_valid, out_data, held);
                end
                held_v = 0;
            end
            if (out_valid && !out_ready) begin held_v = 1; held = out_data; end
            if (out_valid && out_ready) begin
                checks++;
                if (eq_d.size() == 0) begin
                    fails++;
                    $display("FAIL R2 extra byte %h expected none", out_data);
                end else begin
                    int pos, fr;
                    pos = eq_pos[0]; fr = eq_fr[0];
                    if (out_data !== eq_d[0] || out_first !== eq_f[0] || out_last !== eq_l[0]) begin
                        fails++;
                        $display("FAIL %s frame %0d byte %0d: data %h first %b last %b expected %h %b %b",
                                 (out_last !== eq_l[0] && f_len[fr] == 14) ? "R12" : tag_of(pos, fr),
                                 fr, pos, out_data, out_first, out_last, eq_d[0], eq_f[0], eq_l[0]);
                    end
                    if (pos < 64) begin
                        checks++;
                        if (in_ready !== 1'b0) begin
                            fails++;
                            $display("FAIL R9 stall: in_ready=%b at frame %0d byte %0d expected 0", in_ready, fr, pos);
                        end
                    end
                    void'(eq_d.pop_front()); void'(eq_f.pop_front()); void'(eq_l.pop_front());
                    void'(eq_fr.pop_front()); void'(eq_pos.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                acc = 1;
                if (bq_i[ptr] == 13) exp_hdr = 1;
            end
        end
        if (cycles >= LIMIT) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: %0d bytes outstanding expected 0", eq_d.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule